// File: doc/BRIEF.md
# Processor exception entry unit

This block works out, in one step, every architectural register a core rewrites when it enters an exception handler. The core raises a take-exception strobe together with the address of the instruction being abandoned, a cause code, the current machine state word and, for memory faults, the faulting effective address, a store flag and a fault-kind code. On the next clock edge the block presents the new machine state word, the saved return address, the saved status word, the fault address and fault syndrome registers, and the handler fetch address. A one-cycle redirect pulse goes with the fetch address. A double-exception flag shows that the old state was marked non-recoverable when the exception arrived.

The control is a two-state machine. ST_IDLE means no redirect is pending. ST_REDIRECT is the cycle in which the committed registers and the fetch address are presented. An accepted strobe moves ST_IDLE to ST_REDIRECT. A further accepted strobe keeps the machine in ST_REDIRECT. Any cycle without an accepted strobe returns it to ST_IDLE. All bit positions below count bit 0 as the least significant bit of a 64-bit word, or of the 32-bit syndrome.

Top module: `exc_entry_unit`

## Requirements
- R1: On entry, the new machine state equals the old one with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 forced to 0 and bit 63 forced to 1. All other bits are copied.
- R2: The saved return address equals the instruction address. For the system-call cause it is that address plus 4.
- R3: The saved status equals the old machine state ANDed with the keep mask 0xFFFFFFFF87C0FFFF, ORed with the cause-specific reason bits given in R6 and R7.
- R4: Cause codes are: 0 machine check, 1 data storage, 2 instruction storage, 3 external, 4 alignment, 5 program, 6 FP unavailable, 7 decrementer, 8 system call, 9 FP assist. Their handler offsets are, in the same order, 0x200, 0x300, 0x400, 0x500, 0x600, 0x700, 0x800, 0x900, 0xC00 and 0xE00. The fetch address is the offset plus a base. The base is 0xFFFFFFFFFFF00000 when bit 6 of the old machine state is 1, and 0 otherwise.
- R5: A data storage fault writes the effective address to the fault address register. It writes the syndrome as a single bit chosen by the fault kind: 0 hash miss bit 30, 1 direct-store error bit 31, 2 protection bit 27, 3 segment miss bit 21, 4 external-access violation bit 26, 5 external-access disabled bit 20. Bit 25 is added when the access was a store.
- R6: An instruction storage fault ORs one saved-status bit chosen by the fault kind: 0 bit 30, 1 bit 28, 2 bit 27, 3 bit 21, and none for other kinds. It leaves the fault address and syndrome registers unchanged, as every cause other than data storage and alignment does.
- R7: A program exception ORs exactly one saved-status bit chosen by the kind: 0 FP enabled bit 20, 1 illegal instruction bit 19, 2 privileged bit 18, 3 trap bit 17. Kind 4, an unsupported optional instruction, sets bit 19 like an illegal instruction.
- R8: An alignment fault writes the effective address to the fault address register and writes 0 to the syndrome.
- R9: The double-exception flag is 1 in the redirect cycle of an entry whose old machine state had bit 1 clear. It is 0 in every other cycle.
- R10: All registers are committed on the edge that samples an accepted strobe. The redirect output is 1 for exactly the cycle after each accepted strobe, so back-to-back strobes hold it high once per strobe.
- R11: A strobe with cause code 10 to 15 is ignored. No register changes and no redirect occurs.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Take-exception strobe |
| cause_i | input | 4 | Exception cause code |
| cia_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state word |
| ea_i | input | 64 | Faulting effective or operand address |
| is_store_i | input | 1 | Faulting access was a store |
| reason_i | input | 3 | Fault or program-exception kind |
| msr_o | output | 64 | New machine state word |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved status word |
| dar_o | output | 64 | Fault address register |
| dsisr_o | output | 32 | Fault syndrome register |
| fetch_pc_o | output | 64 | Handler fetch address |
| redirect_o | output | 1 | Fetch redirect valid pulse |
| dbl_fault_o | output | 1 | Double-exception error flag |

## Verification
Two functions can act in the same cycle. One is the double-exception flag. The other is the normal register commit, including the syndrome write of a data storage fault. The bench drives a data storage fault whose old machine state has bit 1 clear. It then expects both results in the same redirect cycle: the flag raised, and the fault address, syndrome and saved registers still updated exactly as for a recoverable entry. The redirect pulse of one entry and the commit of the next can also coincide. This is provoked with strobes in consecutive cycles, and each scoreboard item must appear in order with the redirect held high across them.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN     = 64;
    localparam int SYND_W   = 32;
    localparam int CAUSE_W  = 4;
    localparam int RSN_W    = 3;
    localparam int VOFF_W   = 12;
    localparam int VEC_ONES = 44;   // count of high-order ones in the alternate base

    // machine state bit indices (bit 0 = least significant)
    localparam int MB_SF  = XLEN - 1;
    localparam int MB_POW = XLEN - 1 - 45;
    localparam int MB_EE  = XLEN - 1 - 48;
    localparam int MB_PR  = XLEN - 1 - 49;
    localparam int MB_FP  = XLEN - 1 - 50;
    localparam int MB_FE0 = XLEN - 1 - 52;
    localparam int MB_SE  = XLEN - 1 - 53;
    localparam int MB_BE  = XLEN - 1 - 54;
    localparam int MB_FE1 = XLEN - 1 - 55;
    localparam int MB_IP  = XLEN - 1 - 57;
    localparam int MB_IR  = XLEN - 1 - 58;
    localparam int MB_DR  = XLEN - 1 - 59;
    localparam int MB_RI  = XLEN - 1 - 62;

    // saved status reason bits
    localparam int SB_I_HASH   = XLEN - 1 - 33;
    localparam int SB_I_DIRECT = XLEN - 1 - 35;
    localparam int SB_I_PROT   = XLEN - 1 - 36;
    localparam int SB_I_SEG    = XLEN - 1 - 42;
    localparam int SB_P_FPEN   = XLEN - 1 - 43;
    localparam int SB_P_ILL    = XLEN - 1 - 44;
    localparam int SB_P_PRIV   = XLEN - 1 - 45;
    localparam int SB_P_TRAP   = XLEN - 1 - 46;

    // syndrome bits
    localparam int DB_DIRECT = SYND_W - 1 - 0;
    localparam int DB_HASH   = SYND_W - 1 - 1;
    localparam int DB_PROT   = SYND_W - 1 - 4;
    localparam int DB_XVIOL  = SYND_W - 1 - 5;
    localparam int DB_STORE  = SYND_W - 1 - 6;
    localparam int DB_SEG    = SYND_W - 1 - 10;
    localparam int DB_XOFF   = SYND_W - 1 - 11;

    typedef enum logic [CAUSE_W-1:0] {
        CX_MCHK  = 4'd0,
        CX_DSI   = 4'd1,
        CX_ISI   = 4'd2,
        CX_EXT   = 4'd3,
        CX_ALIGN = 4'd4,
        CX_PROG  = 4'd5,
        CX_FPU   = 4'd6,
        CX_DEC   = 4'd7,
        CX_SYSC  = 4'd8,
        CX_FPA   = 4'd9
    } cause_e;

    typedef enum logic [RSN_W-1:0] {
        FR_HASH_MISS = 3'd0,
        FR_DIRECT    = 3'd1,
        FR_PROT      = 3'd2,
        FR_SEG_MISS  = 3'd3,
        FR_XVIOL     = 3'd4,
        FR_XOFF      = 3'd5
    } fault_rsn_e;

    typedef enum logic [RSN_W-1:0] {
        PR_FP_EN    = 3'd0,
        PR_ILLEGAL  = 3'd1,
        PR_PRIV     = 3'd2,
        PR_TRAP     = 3'd3,
        PR_OPTIONAL = 3'd4
    } prog_rsn_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_REDIRECT = 1'b1
    } entry_state_e;

    // true when architectural (MSB-first) position p survives into saved status
    function automatic logic srr1_keeps(input int p);
        return (p <= 32) || (p >= 37 && p <= 41) || (p >= 48);
    endfunction

endpackage

// File: rtl/exc_msr_xform.sv
module exc_msr_xform
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] msr_old,
    output logic [XLEN-1:0] msr_new,
    output logic [XLEN-1:0] srr1_kept
);

    function automatic logic [XLEN-1:0] entry_clear_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[MB_BE]  = 1'b1;
        m[MB_DR]  = 1'b1;
        m[MB_EE]  = 1'b1;
        m[MB_FE0] = 1'b1;
        m[MB_FE1] = 1'b1;
        m[MB_FP]  = 1'b1;
        m[MB_IR]  = 1'b1;
        m[MB_POW] = 1'b1;
        m[MB_PR]  = 1'b1;
        m[MB_RI]  = 1'b1;
        m[MB_SE]  = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] CLR_MASK = entry_clear_mask();
    localparam logic [XLEN-1:0] SET_MASK = {1'b1, {(XLEN-1){1'b0}}};

    assign msr_new = (msr_old & ~CLR_MASK) | SET_MASK;

    // each saved-status bit either follows the old state or is zero
    for (genvar p = 0; p < XLEN; p++) begin : g_keep
        if (srr1_keeps(p)) begin : g_pass
            assign srr1_kept[XLEN-1-p] = msr_old[XLEN-1-p];
        end else begin : g_zero
            assign srr1_kept[XLEN-1-p] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause,
    input  logic               prefix_hi,
    input  logic [XLEN-1:0]    cia,
    output logic               cause_ok,
    output logic [XLEN-1:0]    srr0,
    output logic [XLEN-1:0]    fetch_pc
);

    localparam logic [XLEN-1:0] VEC_BASE = {{VEC_ONES{1'b1}}, {(XLEN-VEC_ONES){1'b0}}};
    localparam logic [XLEN-1:0] SYSC_STEP = XLEN'(4);

    logic [VOFF_W-1:0] offset;

    always_comb begin
        offset   = '0;
        cause_ok = 1'b1;
        srr0     = cia;
        case (cause)
            CX_MCHK:  offset = 12'h200;
            CX_DSI:   offset = 12'h300;
            CX_ISI:   offset = 12'h400;
            CX_EXT:   offset = 12'h500;
            CX_ALIGN: offset = 12'h600;
            CX_PROG:  offset = 12'h700;
            CX_FPU:   offset = 12'h800;
            CX_DEC:   offset = 12'h900;
            CX_SYSC: begin
                offset = 12'hC00;
                srr0   = cia + SYSC_STEP;
            end
            CX_FPA:   offset = 12'hE00;
            default:  cause_ok = 1'b0;
        endcase
    end

    assign fetch_pc = (prefix_hi ? VEC_BASE : '0) + {{(XLEN-VOFF_W){1'b0}}, offset};

endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
    import exc_entry_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause,
    input  logic [RSN_W-1:0]   reason,
    input  logic               is_store,
    output logic [XLEN-1:0]    srr1_rsn,
    output logic               dar_we,
    output logic               dsisr_we,
    output logic [SYND_W-1:0]  dsisr_val
);

    always_comb begin
        srr1_rsn  = '0;
        dar_we    = 1'b0;
        dsisr_we  = 1'b0;
        dsisr_val = '0;
        case (cause)
            CX_DSI: begin
                dar_we   = 1'b1;
                dsisr_we = 1'b1;
                case (reason)
                    FR_HASH_MISS: dsisr_val[DB_HASH]   = 1'b1;
                    FR_DIRECT:    dsisr_val[DB_DIRECT] = 1'b1;
                    FR_PROT:      dsisr_val[DB_PROT]   = 1'b1;
                    FR_SEG_MISS:  dsisr_val[DB_SEG]    = 1'b1;
                    FR_XVIOL:     dsisr_val[DB_XVIOL]  = 1'b1;
                    FR_XOFF:      dsisr_val[DB_XOFF]   = 1'b1;
                    default:      dsisr_val            = '0;
                endcase
                dsisr_val[DB_STORE] = is_store;
            end
            CX_ISI: begin
                case (reason)
                    FR_HASH_MISS: srr1_rsn[SB_I_HASH]   = 1'b1;
                    FR_DIRECT:    srr1_rsn[SB_I_DIRECT] = 1'b1;
                    FR_PROT:      srr1_rsn[SB_I_PROT]   = 1'b1;
                    FR_SEG_MISS:  srr1_rsn[SB_I_SEG]    = 1'b1;
                    default:      srr1_rsn              = '0;
                endcase
            end
            CX_ALIGN: begin
                dar_we   = 1'b1;
                dsisr_we = 1'b1;
            end
            CX_PROG: begin
                case (reason)
                    PR_FP_EN:    srr1_rsn[SB_P_FPEN] = 1'b1;
                    PR_ILLEGAL,
                    PR_OPTIONAL: srr1_rsn[SB_P_ILL]  = 1'b1;
                    PR_PRIV:     srr1_rsn[SB_P_PRIV] = 1'b1;
                    PR_TRAP:     srr1_rsn[SB_P_TRAP] = 1'b1;
                    default:     srr1_rsn            = '0;
                endcase
            end
            default: begin
                dar_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    cia_i,
    input  logic [XLEN-1:0]    msr_i,
    input  logic [XLEN-1:0]    ea_i,
    input  logic               is_store_i,
    input  logic [RSN_W-1:0]   reason_i,
    output logic [XLEN-1:0]    msr_o,
    output logic [XLEN-1:0]    srr0_o,
    output logic [XLEN-1:0]    srr1_o,
    output logic [XLEN-1:0]    dar_o,
    output logic [SYND_W-1:0]  dsisr_o,
    output logic [XLEN-1:0]    fetch_pc_o,
    output logic               redirect_o,
    output logic               dbl_fault_o
);

    logic [XLEN-1:0]   msr_new, srr1_kept, srr1_rsn, srr0_nx, fetch_nx;
    logic [SYND_W-1:0] dsisr_nx;
    logic              cause_ok, dar_we, dsisr_we, accept;
    entry_state_e      state_q, state_nx;

    exc_msr_xform u_msr (
        .msr_old   (msr_i),
        .msr_new   (msr_new),
        .srr1_kept (srr1_kept)
    );

    exc_vector_sel u_vec (
        .cause     (cause_i),
        .prefix_hi (msr_i[MB_IP]),
        .cia       (cia_i),
        .cause_ok  (cause_ok),
        .srr0      (srr0_nx),
        .fetch_pc  (fetch_nx)
    );

    exc_syndrome u_syn (
        .cause     (cause_i),
        .reason    (reason_i),
        .is_store  (is_store_i),
        .srr1_rsn  (srr1_rsn),
        .dar_we    (dar_we),
        .dsisr_we  (dsisr_we),
        .dsisr_val (dsisr_nx)
    );

    assign accept = take_i && cause_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state_q)
            ST_IDLE:     state_nx = accept ? ST_REDIRECT : ST_IDLE;
            ST_REDIRECT: state_nx = accept ? ST_REDIRECT : ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state-decoded output
    always_comb begin
        redirect_o = 1'b0;
        unique case (state_q)
            ST_REDIRECT: redirect_o = 1'b1;
            default:     redirect_o = 1'b0;
        endcase
    end

    // architectural register commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_o       <= '0;
            srr0_o      <= '0;
            srr1_o      <= '0;
            dar_o       <= '0;
            dsisr_o     <= '0;
            fetch_pc_o  <= '0;
            dbl_fault_o <= 1'b0;
        end else if (accept) begin
            msr_o       <= msr_new;
            srr0_o      <= srr0_nx;
            srr1_o      <= srr1_kept | srr1_rsn;
            fetch_pc_o  <= fetch_nx;
            dbl_fault_o <= ~msr_i[MB_RI];
            if (dar_we)   dar_o   <= ea_i;
            if (dsisr_we) dsisr_o <= dsisr_nx;
        end else begin
            dbl_fault_o <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               take_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic [XLEN-1:0]    cia_i,
    input logic [XLEN-1:0]    msr_i,
    input logic [XLEN-1:0]    msr_o,
    input logic [XLEN-1:0]    srr0_o,
    input logic [XLEN-1:0]    srr1_o,
    input logic [XLEN-1:0]    fetch_pc_o,
    input logic               redirect_o,
    input logic               dbl_fault_o
);

    function automatic logic [XLEN-1:0] keep_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int p = 0; p < XLEN; p++) m[XLEN-1-p] = srr1_keeps(p);
        return m;
    endfunction

    localparam logic [XLEN-1:0] KEEP = keep_mask();

    logic legal_take, bad_take;
    assign legal_take = take_i && (cause_i <= 4'd9);
    assign bad_take   = take_i && (cause_i > 4'd9);

    a_r1_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (msr_o[MB_SF] && !msr_o[MB_RI] && !msr_o[MB_EE] && !msr_o[MB_PR]));

    a_r2_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
        legal_take |=> srr0_o == ($past(cia_i) + (($past(cause_i) == 4'd8) ? 64'd4 : 64'd0)));

    a_r3_status_copy: assert property (@(posedge clk) disable iff (!rst_n)
        legal_take |=> (srr1_o & KEEP) == ($past(msr_i) & KEEP));

    a_r4_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (fetch_pc_o[7:0] == 8'h0 && fetch_pc_o[19:12] == 8'h0
                        && (&fetch_pc_o[63:20] || ~|fetch_pc_o[63:20])));

    a_r9_double_flag: assert property (@(posedge clk) disable iff (!rst_n)
        legal_take |=> dbl_fault_o == !$past(msr_i[MB_RI]));

    a_r9_flag_in_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_fault_o |-> redirect_o);

    a_r10_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
        legal_take |=> redirect_o);

    a_r10_no_stray_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_take |=> !redirect_o);

    a_r11_bad_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        bad_take |=> ($stable(srr0_o) && $stable(msr_o) && $stable(fetch_pc_o)));

endmodule

bind exc_entry_unit exc_entry_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .cause_i     (cause_i),
    .cia_i       (cia_i),
    .msr_i       (msr_i),
    .msr_o       (msr_o),
    .srr0_o      (srr0_o),
    .srr1_o      (srr1_o),
    .fetch_pc_o  (fetch_pc_o),
    .redirect_o  (redirect_o),
    .dbl_fault_o (dbl_fault_o)
);

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb;

    localparam logic [63:0] CLR  = 64'h0000_0000_0004_EF32;
    localparam logic [63:0] KEEP = 64'hFFFF_FFFF_87C0_FFFF;
    localparam logic [63:0] BASE = 64'hFFFF_FFFF_FFF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic [3:0]  cause_i = '0;
    logic [63:0] cia_i = '0, msr_i = '0, ea_i = '0;
    logic        is_store_i = 1'b0;
    logic [2:0]  reason_i = '0;
    logic [63:0] msr_o, srr0_o, srr1_o, dar_o, fetch_pc_o;
    logic [31:0] dsisr_o;
    logic        redirect_o, dbl_fault_o;

    always #2.5 clk = ~clk;

    exc_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .cause_i(cause_i),
        .cia_i(cia_i), .msr_i(msr_i), .ea_i(ea_i), .is_store_i(is_store_i),
        .reason_i(reason_i), .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
        .dar_o(dar_o), .dsisr_o(dsisr_o), .fetch_pc_o(fetch_pc_o),
        .redirect_o(redirect_o), .dbl_fault_o(dbl_fault_o)
    );

    typedef struct {
        logic [63:0] msr, srr0, srr1, dar, pc;
        logic [31:0] dsisr;
        logic        dbl;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        last;
    logic [63:0] m_dar = '0;
    logic [31:0] m_dsisr = '0;
    int          n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dsi_code(input logic [2:0] r);
        case (r)
            3'd0: return 32'h4000_0000;
            3'd1: return 32'h8000_0000;
            3'd2: return 32'h0800_0000;
            3'd3: return 32'h0020_0000;
            3'd4: return 32'h0400_0000;
            3'd5: return 32'h0010_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [63:0] isi_code(input logic [2:0] r);
        case (r)
            3'd0: return 64'h4000_0000;
            3'd1: return 64'h1000_0000;
            3'd2: return 64'h0800_0000;
            3'd3: return 64'h0020_0000;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] prog_code(input logic [2:0] r);
        case (r)
            3'd0: return 64'h0010_0000;
            3'd1, 3'd4: return 64'h0008_0000;
            3'd2: return 64'h0004_0000;
            3'd3: return 64'h0002_0000;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] vec_off(input logic [3:0] c);
        case (c)
            4'd8: return 64'hC00;
            4'd9: return 64'hE00;
            default: return {52'h0, c + 4'd2, 8'h00};
        endcase
    endfunction

    // driver: computes the expected item, queues it, applies one strobe cycle
    task automatic fire(input logic [3:0] c, input logic [63:0] pc, input logic [63:0] msr,
                        input logic [63:0] ea, input logic st, input logic [2:0] rs);
        exp_t e;
        logic [63:0] rbits;
        rbits   = '0;
        e.tag   = "R3";
        e.msr   = (msr & ~CLR) | 64'h8000_0000_0000_0000;
        e.srr0  = (c == 4'd8) ? pc + 64'd4 : pc;
        case (c)
            4'd1: begin m_dar = ea; m_dsisr = dsi_code(rs) | (st ? 32'h0200_0000 : 32'h0); e.tag = "R5"; end
            4'd2: begin rbits = isi_code(rs); e.tag = "R6"; end
            4'd4: begin m_dar = ea; m_dsisr = 32'h0; e.tag = "R8"; end
            4'd5: begin rbits = prog_code(rs); e.tag = "R7"; end
            default: ;
        endcase
        e.srr1  = (msr & KEEP) | rbits;
        e.dar   = m_dar;
        e.dsisr = m_dsisr;
        e.pc    = (msr[6] ? BASE : 64'h0) + vec_off(c);
        e.dbl   = !msr[1];
        sb_q.push_back(e);
        last = e;
        take_i = 1'b1; cause_i = c; cia_i = pc; msr_i = msr;
        ea_i = ea; is_store_i = st; reason_i = rs;
        @(negedge clk);
        take_i = 1'b0;
    endtask

    task automatic idle(input int n);
        take_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected item per redirect cycle
    always @(negedge clk) begin
        if (rst_n && redirect_o) begin
            if (sb_q.size() == 0) begin
                chk("R10", "unexpected redirect", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R1", "msr", msr_o, e.msr);
                chk("R2", "srr0", srr0_o, e.srr0);
                chk(e.tag, "srr1", srr1_o, e.srr1);
                chk("R4", "fetch_pc", fetch_pc_o, e.pc);
                chk(e.tag, "dar", dar_o, e.dar);
                chk(e.tag, "dsisr", {32'h0, dsisr_o}, {32'h0, e.dsisr});
                chk("R9", "dbl_fault", {63'h0, dbl_fault_o}, {63'h0, e.dbl});
            end
        end else if (rst_n) begin
            chk("R9", "flag outside redirect", {63'h0, dbl_fault_o}, 64'h0);
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    localparam logic [63:0] MA = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MB = 64'h0123_4567_89AB_CDE2;
    localparam logic [63:0] MC = 64'h0000_0000_0000_0002;
    localparam logic [63:0] MD = 64'h5A5A_5A5A_A5A5_A5A5;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "msr", msr_o, 64'h0);
        chk("R12", "srr0", srr0_o, 64'h0);
        chk("R12", "srr1", srr1_o, 64'h0);
        chk("R12", "dar", dar_o, 64'h0);
        chk("R12", "dsisr", {32'h0, dsisr_o}, 64'h0);
        chk("R12", "fetch_pc", fetch_pc_o, 64'h0);
        chk("R12", "redirect", {63'h0, redirect_o}, 64'h0);

        // R1 R2 R4: plain causes, both vector bases
        fire(4'd0, 64'h0000_0000_0000_1000, MC, 64'h0, 1'b0, 3'd0); idle(1);
        fire(4'd3, 64'h0000_0000_0000_2004, MA, 64'h0, 1'b0, 3'd0); idle(1);
        fire(4'd6, 64'h0000_0000_0000_3008, MB, 64'h0, 1'b0, 3'd0); idle(1);
        fire(4'd7, 64'h0000_0000_0000_4000, MC, 64'h0, 1'b0, 3'd0); idle(1);
        fire(4'd8, 64'h0000_0000_0000_5FFC, MB, 64'h0, 1'b0, 3'd0); idle(1);
        fire(4'd9, 64'hFFFF_FFFF_FFFF_FFFC, MA, 64'h0, 1'b0, 3'd0); idle(1);

        // R5: every data storage fault kind, loads and stores
        for (int r = 0; r < 6; r++) begin
            fire(4'd1, 64'h100 + 64'(r * 4), (r % 2 == 1) ? MA : MC,
                 64'hABCD_0000_0000_0000 + 64'(r), r[0], 3'(r));
            idle(1);
        end

        // R6: instruction storage kinds incl. one with no reason bit
        for (int r = 0; r < 6; r++) begin
            fire(4'd2, 64'h200 + 64'(r * 4), MB, 64'hDEAD_BEEF_0000_0000, 1'b0, 3'(r));
            idle(1);
        end

        // R7: program exception kinds incl. optional instruction
        for (int r = 0; r < 5; r++) begin
            fire(4'd5, 64'h300 + 64'(r * 4), MA, 64'h0, 1'b0, 3'(r));
            idle(1);
        end

        // R8: alignment clears syndrome
        fire(4'd4, 64'h0000_0000_0000_0400, MC, 64'h0000_0000_1234_5671, 1'b1, 3'd0); idle(1);

        // R9 with R5: non-recoverable data storage fault, flag and syndrome together
        fire(4'd1, 64'h0000_0000_0000_0500, MD, 64'h0000_0000_0000_0F00, 1'b1, 3'd2); idle(1);

        // R10: back-to-back strobes
        fire(4'd3, 64'h600, MA, 64'h0, 1'b0, 3'd0);
        fire(4'd5, 64'h604, MD, 64'h0, 1'b0, 3'd3);
        fire(4'd4, 64'h608, MB, 64'h0000_0000_0000_0777, 1'b0, 3'd0);
        idle(1);
        chk("R10", "redirect after burst", {63'h0, redirect_o}, 64'h0);
        idle(1);

        // R11: illegal cause codes leave all registers untouched
        for (int c = 10; c < 16; c++) begin
            take_i = 1'b1; cause_i = 4'(c); cia_i = 64'hFFFF_0000_FFFF_0000;
            msr_i = MD; ea_i = 64'h1111_2222_3333_4444; reason_i = 3'd1;
            @(negedge clk);
            take_i = 1'b0;
            chk("R11", "redirect", {63'h0, redirect_o}, 64'h0);
            chk("R11", "srr0", srr0_o, last.srr0);
            chk("R11", "msr", msr_o, last.msr);
            chk("R11", "dar", dar_o, last.dar);
            chk("R11", "dsisr", {32'h0, dsisr_o}, {32'h0, last.dsisr});
            chk("R11", "fetch_pc", fetch_pc_o, last.pc);
        end

        idle(3);
        chk("R10", "scoreboard drained", 64'(sb_q.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule